// File: doc/BRIEF.md
# Quasi-Cyclic Soft-Value Rotator

This block cyclically rotates a vector of soft values (log-likelihood ratios) by a run-time amount modulo the expansion factor Z of a quasi-cyclic parity-check layer. Z can be 27, 54 or 81. Rotation toward the processing units (left) applies the circulant permutation of a layer. Rotation back toward storage (right) applies the inverse. One datapath serves both directions.

Z is not a power of two, so a single barrel shifter cannot wrap at Z. The block pads the active lanes into a 128-lane field and feeds two 128-lane rotators with computed amounts. One rotator supplies the lanes that do not wrap and the other supplies the lanes that wrap around Z. A per-lane select merges the two, and lanes at or above Z are forced to zero. The result is registered, so every rotation takes one clock.

Top module: `qc_llr_rotator`

## Requirements
- R1: While `rst_n` is low, `dout` is all zeros.
- R2: `dout` shows the rotation of the inputs sampled at the previous rising edge of `clk`. It does not change before that edge.
- R3: `z_code` selects Z as follows: 0 gives 27, 1 gives 54, 2 gives 81, and 3 is treated as 81.
- R4: With `dir_right` = 0 (left), output lane i for i < Z equals input lane (i + c) mod Z, where c is `shift_amt`. Lane i occupies bits [7i+6:7i] of `din` and `dout`.
- R5: With `dir_right` = 1 (right), output lane i for i < Z equals input lane (i − c) mod Z.
- R6: Output lanes at index Z or above are zero. Input lanes at index Z or above have no effect on any output lane.
- R7: When `shift_amt` is 0, output lanes below Z equal the input lanes in either direction.
- R8: A left rotation by c, followed by a right rotation by c of that result, returns the original lanes below Z, for every Z and every c < Z.
- R9: `shift_amt` must be less than Z. This is an interface precondition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| din | input | 567 | 81 lanes of 7-bit soft values, lane 0 in the low bits |
| z_code | input | 2 | Expansion factor select |
| shift_amt | input | 7 | Rotation amount c, less than Z |
| dir_right | input | 1 | 0 = left rotation, 1 = right rotation |
| dout | output | 567 | Rotated lanes, registered |

## Verification
Every result is due exactly one rising edge after its inputs are applied. The bench drives inputs on a falling edge and compares `dout` on the following falling edge. In the latency check it also samples once just before the edge, to confirm the old value is still held. The round-trip identity is checked by capturing the left result at that falling edge and feeding it back as the input of a right rotation. The identity result is then due one edge later.

// File: rtl/qc_rot_pkg.sv
package qc_rot_pkg;
  typedef enum logic {
    ROT_LEFT  = 1'b0,
    ROT_RIGHT = 1'b1
  } rot_dir_e;
endpackage

// File: rtl/qc_barrel_rotl.sv
module qc_barrel_rotl #(
  parameter int N  = 128,
  parameter int W  = 7,
  parameter int SW = $clog2(N)
) (
  input  logic [N*W-1:0] vec_in,
  input  logic [SW-1:0]  amt,
  output logic [N*W-1:0] vec_out
);
  // stage s rotates toward lane 0 by 2**s lanes when amt[s] is set
  logic [N*W-1:0] stage [SW+1];

  assign stage[0] = vec_in;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int K = 1 << s;
    assign stage[s+1] = amt[s] ? {stage[s][K*W-1:0], stage[s][N*W-1:K*W]}
                               : stage[s];
  end

  assign vec_out = stage[SW];
endmodule

// File: rtl/qc_lane_merge.sv
module qc_lane_merge #(
  parameter int N     = 128,
  parameter int LANES = 81,
  parameter int W     = 7,
  parameter int SW    = $clog2(N)
) (
  input  logic [N*W-1:0]     low_src,
  input  logic [N*W-1:0]     high_src,
  input  logic [SW-1:0]      bound,
  input  logic [SW-1:0]      zval,
  output logic [LANES*W-1:0] lanes_out
);
  // lanes below bound come from low_src, the rest from high_src, zero from Z up
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [SW-1:0] IDX = SW'(i);
    assign lanes_out[i*W +: W] = (IDX >= zval) ? '0 :
                                 (IDX < bound) ? low_src[i*W +: W] :
                                                 high_src[i*W +: W];
  end
endmodule

// File: rtl/qc_llr_rotator.sv
module qc_llr_rotator
  import qc_rot_pkg::*;
#(
  parameter int ZMAX  = 128,
  parameter int LANES = 81,
  parameter int W     = 7,
  parameter int ZBASE = 27,
  parameter int SW    = $clog2(ZMAX)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LANES*W-1:0]   din,
  input  logic [1:0]           z_code,
  input  logic [SW-1:0]        shift_amt,
  input  logic                 dir_right,
  output logic [LANES*W-1:0]   dout
);
  localparam int PADW = (ZMAX - LANES) * W;

  logic [SW-1:0]       zval;
  logic [SW:0]         amt1_w;
  logic [SW-1:0]       amt1, amt2, bound;
  logic [ZMAX*W-1:0]   padded, rot1, rot2;
  logic [LANES*W-1:0]  merged;
  logic [LANES*W-1:0]  dout_d;
  logic [SW-1:0]       z_q;
  logic [SW-1:0]       z_d;
  rot_dir_e            dir;

  assign dir    = rot_dir_e'(dir_right);
  assign padded = {{PADW{1'b0}}, din};

  // expansion factor decode; code 3 folds onto the largest factor
  always_comb begin
    unique case (z_code)
      2'd0:    zval = SW'(ZBASE);
      2'd1:    zval = SW'(2 * ZBASE);
      default: zval = SW'(3 * ZBASE);
    endcase
  end

  // shift amounts for the two rotators and the merge boundary
  always_comb begin
    if (dir == ROT_LEFT) begin
      amt1_w = (SW+1)'(ZMAX) - {1'b0, zval} + {1'b0, shift_amt};
      amt2   = shift_amt;
      bound  = zval - shift_amt;
    end else begin
      amt1_w = (SW+1)'(ZMAX) - {1'b0, shift_amt};
      amt2   = zval - shift_amt;
      bound  = shift_amt;
    end
    amt1 = amt1_w[SW-1:0];
  end

  qc_barrel_rotl #(.N(ZMAX), .W(W), .SW(SW)) u_rot_wrap (
    .vec_in (padded),
    .amt    (amt1),
    .vec_out(rot1)
  );

  qc_barrel_rotl #(.N(ZMAX), .W(W), .SW(SW)) u_rot_direct (
    .vec_in (padded),
    .amt    (amt2),
    .vec_out(rot2)
  );

  qc_lane_merge #(.N(ZMAX), .LANES(LANES), .W(W), .SW(SW)) u_merge (
    .low_src  (rot2),
    .high_src (rot1),
    .bound    (bound),
    .zval     (zval),
    .lanes_out(merged)
  );

  // next state
  always_comb begin
    dout_d = merged;
    z_d    = zval;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      z_q  <= '0;
    end else begin
      dout <= dout_d;
      z_q  <= z_d;
    end
  end

  // ---------------------------------------------------------------- checks
  function automatic logic [W-1:0] lane_of(input logic [LANES*W-1:0] v,
                                           input logic [SW-1:0] idx);
    lane_of = (int'(idx) < LANES) ? v[int'(idx)*W +: W] : '0;
  endfunction

  function automatic logic [LANES*W-1:0] low_mask(input logic [SW-1:0] z);
    for (int i = 0; i < LANES; i++)
      low_mask[i*W +: W] = (i < int'(z)) ? {W{1'b1}} : '0;
  endfunction

  logic upper_nonzero;
  always_comb begin
    upper_nonzero = 1'b0;
    for (int i = 0; i < LANES; i++)
      if (i >= int'(z_q) && dout[i*W +: W] != '0) upper_nonzero = 1'b1;
  end

  AST_SHIFT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_amt < zval); // R9

  AST_UPPER_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !upper_nonzero); // R6

  AST_LEFT_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_right == 1'b0) |=> lane_of(dout, '0) == $past(lane_of(din, shift_amt))); // R4

  AST_RIGHT_LANE_C: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_right == 1'b1) |=> lane_of(dout, $past(shift_amt)) == $past(lane_of(din, '0))); // R5

  AST_ZERO_SHIFT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_amt == '0) |=> dout == $past(din & low_mask(zval))); // R7
endmodule

// File: tb/tb_qc_llr_rotator.sv
module tb_qc_llr_rotator;
  localparam int LANES = 81;
  localparam int W     = 7;
  localparam int SW    = 7;
  localparam int SEED  = 1234;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [LANES*W-1:0]   din;
  logic [1:0]           z_code;
  logic [SW-1:0]        shift_amt;
  logic                 dir_right;
  logic [LANES*W-1:0]   dout;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  qc_llr_rotator dut (
    .clk(clk), .rst_n(rst_n), .din(din), .z_code(z_code),
    .shift_amt(shift_amt), .dir_right(dir_right), .dout(dout)
  );

  function automatic int z_of(input logic [1:0] code);
    case (code)
      2'd0:    z_of = 27;
      2'd1:    z_of = 54;
      default: z_of = 81;
    endcase
  endfunction

  function automatic logic [LANES*W-1:0] exp_rot(input logic [LANES*W-1:0] d,
      input int z, input int c, input bit right);
    exp_rot = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i < z) begin
        int src;
        src = right ? (i - c + z) % z : (i + c) % z;
        exp_rot[i*W +: W] = d[src*W +: W];
      end
    end
  endfunction

  function automatic logic [LANES*W-1:0] mask_z(input logic [LANES*W-1:0] d, input int z);
    mask_z = '0;
    for (int i = 0; i < z; i++) mask_z[i*W +: W] = d[i*W +: W];
  endfunction

  function automatic logic [LANES*W-1:0] rand_vec();
    for (int i = 0; i < LANES; i++) rand_vec[i*W +: W] = W'($urandom);
  endfunction

  task automatic check(input string tag, input logic [LANES*W-1:0] got,
                       input logic [LANES*W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // drive on a falling edge, result is compared on the next falling edge
  task automatic apply(input logic [LANES*W-1:0] d, input logic [1:0] code,
                       input int c, input bit right);
    @(negedge clk);
    din       = d;
    z_code    = code;
    shift_amt = SW'(c);
    dir_right = right;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [LANES*W-1:0] v, mid, prev;
    void'($urandom(SEED));
    rst_n = 1'b0; din = rand_vec(); z_code = 2'd2; shift_amt = 7'd5; dir_right = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset state", dout, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: one-edge latency, old value still held just before the edge
    apply(rand_vec(), 2'd0, 3, 1'b0);
    prev = dout;
    @(negedge clk);
    v = rand_vec();
    din = v; z_code = 2'd1; shift_amt = 7'd10; dir_right = 1'b0;
    @(posedge clk); #0;
    check("R2 held before edge", dout, prev);
    @(negedge clk);
    check("R2 due after one edge", dout, exp_rot(v, 54, 10, 1'b0));

    // R3: code mapping, code 3 same as 81
    for (int k = 0; k < 4; k++) begin
      v = rand_vec();
      apply(v, 2'(k), 1, 1'b0);
      check("R3 z decode", dout, exp_rot(v, z_of(2'(k)), 1, 1'b0));
    end

    // directed corners: c = Z-1 both ways (R4, R5), c = 0 (R7)
    for (int k = 0; k < 3; k++) begin
      int z;
      z = z_of(2'(k));
      v = rand_vec();
      apply(v, 2'(k), z - 1, 1'b0);
      check("R4 left c=Z-1", dout, exp_rot(v, z, z - 1, 1'b0));
      apply(v, 2'(k), z - 1, 1'b1);
      check("R5 right c=Z-1", dout, exp_rot(v, z, z - 1, 1'b1));
      apply(v, 2'(k), 0, 1'b0);
      check("R7 zero shift left", dout, mask_z(v, z));
      apply(v, 2'(k), 0, 1'b1);
      check("R7 zero shift right", dout, mask_z(v, z));
    end

    // R6: upper input lanes have no effect, upper outputs zero
    v = rand_vec();
    apply(v, 2'd0, 7, 1'b1);
    prev = dout;
    mid = v;
    for (int i = 27; i < LANES; i++) mid[i*W +: W] = ~v[i*W +: W];
    apply(mid, 2'd0, 7, 1'b1);
    check("R6 upper inputs ignored", dout, prev);
    check("R6 upper outputs zero", dout, mask_z(dout, 27));

    // random rotations
    for (int n = 0; n < 400; n++) begin
      logic [1:0] code;
      int c;
      bit r;
      code = 2'($urandom_range(3));
      c    = $urandom_range(z_of(code) - 1);
      r    = 1'($urandom);
      v    = rand_vec();
      apply(v, code, c, r);
      check(r ? "R5 random right" : "R4 random left", dout, exp_rot(v, z_of(code), c, r));
    end

    // R8: round trip over every Z and every c
    for (int k = 0; k < 3; k++) begin
      int z;
      z = z_of(2'(k));
      for (int c = 0; c < z; c++) begin
        v = rand_vec();
        apply(v, 2'(k), c, 1'b0);
        mid = dout;
        apply(mid, 2'(k), c, 1'b1);
        check("R8 left then right", dout, mask_z(v, z));
      end
    end

    finish_run();
  end
endmodule